// File: doc/BRIEF.md
# Horizontal Line Counter and Phase Comparator

This block is the digital half of a horizontal line-locked loop. It runs from the external VCO clock and divides it by the line length of the selected panel mode, 638 or 702 clocks per line. The result is an internal line position and a one-clock reference pulse at the start of every line. A phase comparator watches the low sync-tip interval of composite sync. For the whole of that interval it drives a three-state error signal. The signal is low while the line position is before the midpoint of the line and high from the midpoint on. When a sync tip is centred on the midpoint, the rising edge of the error signal falls at the centre of the tip. An external lag-lead filter turns the error pulses into a control voltage for the VCO.

When there is no signal, the no-signal flag releases the error output to high impedance, so the filter holds its charge. The counter keeps running freely in that state. The block carries no data stream: every pin is a plain control or status level, so no valid/ready handshake or back-pressure applies. The counter is never reset by sync. Phase is corrected only through the external VCO.

Top module: `hline_phase_comparator`

## Requirements
- R1: `hcount` advances by one on every clock. It returns to 0 after reaching L-1, where L is 638 while the latched mode is 0 and 702 while it is 1.
- R2: `href` is high for exactly one cycle, the cycle in which `hcount` is 0 after a wrap. It is not high in the first line after reset.
- R3: `mode_long` is sampled only on the clock edge that wraps the counter and sets the length of the following line. Changes in mid-line leave the current line's length unchanged.
- R4: `err_oe` is 1 in the cycle after a clock edge at which `sync_n` was 0 and `no_sig` was 0, and 0 otherwise.
- R5: While driving, `err_out` is 0 if `hcount` at the sampling edge was below L/2 (319 or 351) and 1 otherwise. A tip that spans a wrap therefore shows 1 up to L-1 and then 0 from count 0.
- R6: `err_out` is 0 whenever `err_oe` is 0.
- R7: While `no_sig` is 1, `err_oe` stays 0 and the counter keeps counting without disturbance.
- R8: During and just after reset, `hcount`, `href`, `err_oe` and `err_out` are 0, and the first line is 638 clocks long whatever `mode_long` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_long | input | 1 | Line length select: 0 gives 638, 1 gives 702 |
| sync_n | input | 1 | Composite sync level, low during the sync tip |
| no_sig | input | 1 | No-signal flag; forces the error output to high impedance |
| err_out | output | 1 | Phase error level toward the loop filter |
| err_oe | output | 1 | Output enable for `err_out` (0 = high impedance) |
| hcount | output | 10 | Current position within the line |
| href | output | 1 | One-clock pulse at the start of each line |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the counter wrap and the comparator's drive. The bench holds sync low across the last counts of a line and the first counts of the next, in both modes, and expects the error level to drop from high to low exactly as the count returns to 0. The second pair is the wrap and a mode change. The bench switches `mode_long` on the very cycle that `hcount` shows L-1 and expects the new length to apply to the next line. It then switches again in mid-line and expects no effect until the following wrap. Line lengths are judged by counting clocks between `href` pulses.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef enum logic {
    LINE_SHORT = 1'b0,
    LINE_LONG  = 1'b1
  } line_mode_e;

  // Width needed to hold a count up to len-1
  function automatic int unsigned cnt_width(input int unsigned len);
    return (len <= 2) ? 1 : $clog2(len);
  endfunction

endpackage

// File: rtl/hpc_line_counter.sv
module hpc_line_counter
  import hpc_pkg::*;
#(
  parameter int unsigned LEN_SHORT = 638,
  parameter int unsigned LEN_LONG  = 702,
  parameter int unsigned CW        = cnt_width(LEN_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_req,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] mid_o,
  output logic          line_start_o
);

  localparam logic [CW-1:0] LAST_SHORT = CW'(LEN_SHORT - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(LEN_LONG - 1);
  localparam logic [CW-1:0] MID_SHORT  = CW'(LEN_SHORT / 2);
  localparam logic [CW-1:0] MID_LONG   = CW'(LEN_LONG / 2);

  line_mode_e    mode_q;
  logic [CW-1:0] cnt_q;
  logic          start_q;
  logic          at_last;

  always_comb begin
    at_last = (mode_q == LINE_LONG) ? (cnt_q == LAST_LONG) : (cnt_q == LAST_SHORT);
    mid_o   = (mode_q == LINE_LONG) ? MID_LONG : MID_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mode_q  <= LINE_SHORT;
      start_q <= 1'b0;
    end else begin
      start_q <= at_last;
      if (at_last) begin
        cnt_q  <= '0;
        mode_q <= line_mode_e'(mode_req);
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign count_o      = cnt_q;
  assign line_start_o = start_q;

endmodule

// File: rtl/hpc_phase_det.sv
module hpc_phase_det #(
  parameter int unsigned CW          = 10,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          no_sig,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] mid_i,
  output logic          err_o,
  output logic          oe_o
);

  logic tip;

  // Optional resampling of the sync level before the comparator
  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign tip = ~sync_n;
    end else begin : g_resync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sync_n} & {SYNC_STAGES{1'b1}};
      end
      assign tip = ~sh_q[SYNC_STAGES-1];
    end
  endgenerate

  logic drive, late;

  always_comb begin
    drive = tip & ~no_sig;
    late  = (count_i >= mid_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      oe_o  <= drive;
      err_o <= drive & late;
    end
  end

endmodule

// File: rtl/hline_phase_comparator.sv
module hline_phase_comparator
  import hpc_pkg::*;
#(
  parameter int unsigned LEN_SHORT   = 638,
  parameter int unsigned LEN_LONG    = 702,
  parameter int unsigned SYNC_STAGES = 0,
  localparam int unsigned CW         = cnt_width(LEN_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_long,
  input  logic          sync_n,
  input  logic          no_sig,
  output logic          err_out,
  output logic          err_oe,
  output logic [CW-1:0] hcount,
  output logic          href
);

  logic [CW-1:0] mid;

  hpc_line_counter #(
    .LEN_SHORT(LEN_SHORT),
    .LEN_LONG (LEN_LONG),
    .CW       (CW)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_req    (mode_long),
    .count_o     (hcount),
    .mid_o       (mid),
    .line_start_o(href)
  );

  hpc_phase_det #(
    .CW         (CW),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pd (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .no_sig (no_sig),
    .count_i(hcount),
    .mid_i  (mid),
    .err_o  (err_out),
    .oe_o   (err_oe)
  );

endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int unsigned LEN_LONG = 702,
  parameter int unsigned CW       = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_n,
  input logic          no_sig,
  input logic          err_out,
  input logic          err_oe,
  input logic [CW-1:0] hcount,
  input logic          href
);

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hcount <= CW'(LEN_LONG - 1)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount != '0) |-> (hcount == CW'($past(hcount) + 1'b1))); // R1

  AST_HREF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    href |-> (hcount == '0)); // R2

  AST_HREF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    href |=> !href); // R2

  AST_OE_NEEDS_TIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_oe) |-> ($past(!sync_n) && $past(!no_sig))); // R4

  AST_QUIET_WHEN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !err_oe |-> !err_out); // R6

  AST_NOSIG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    no_sig |=> !err_oe); // R7

endmodule

bind hline_phase_comparator hpc_checker #(
  .LEN_LONG(LEN_LONG),
  .CW      (CW)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .sync_n (sync_n),
  .no_sig (no_sig),
  .err_out(err_out),
  .err_oe (err_oe),
  .hcount (hcount),
  .href   (href)
);

// File: tb/hline_phase_comparator_tb_top.sv
module hline_phase_comparator_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_long = 1'b0;
  logic       sync_n = 1'b1;
  logic       no_sig = 1'b0;
  logic       err_out, err_oe, href;
  logic [9:0] hcount;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hline_phase_comparator dut_i (
    .clk(clk), .rst_n(rst_n), .mode_long(mode_long), .sync_n(sync_n),
    .no_sig(no_sig), .err_out(err_out), .err_oe(err_oe),
    .hcount(hcount), .href(href)
  );

  typedef struct packed {
    logic        md;
    logic        ns;
    logic [15:0] st;
    logic [15:0] ln;
  } vec_t;

  // mode, no-signal, tip start count, tip length
  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 16'd296, 16'd47},  // centred tip, short line
    '{1'b1, 1'b0, 16'd328, 16'd47},  // centred tip, long line
    '{1'b0, 1'b0, 16'd630, 16'd16},  // tip across wrap, short line
    '{1'b1, 1'b0, 16'd690, 16'd20},  // tip across wrap, long line
    '{1'b0, 1'b1, 16'd300, 16'd30},  // no signal
    '{1'b1, 1'b0, 16'd10,  16'd5},   // wholly early
    '{1'b0, 1'b0, 16'd400, 16'd10},  // wholly late
    '{1'b1, 1'b0, 16'd349, 16'd4}    // straddles midpoint 351
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_href();
    do @(negedge clk); while (href !== 1'b1);
  endtask

  task automatic measure_line(output int n, input int flip_at);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == flip_at) mode_long = ~mode_long;
    end while (href !== 1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int n;
    // R8: reset state, with long mode requested from the start
    mode_long = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 hcount in reset", hcount, 0);
    chk("R8 href in reset", href, 0);
    chk("R8 err_oe in reset", err_oe, 0);
    chk("R8 err_out in reset", err_out, 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (href !== 1'b1);
    chk("R8 first line length", n, 638);
    chk("R2 href at zero", hcount, 0);
    @(negedge clk);
    chk("R2 href single cycle", href, 0);

    // Vector table walk: R4 R5 R6 R7 R1
    for (int v = 0; v < 8; v++) begin
      int len, mid, ex;
      len = VECS[v].md ? 702 : 638;
      mid = len / 2;
      mode_long = VECS[v].md;
      wait_href();
      wait_href();
      while (hcount != 10'(VECS[v].st)) @(negedge clk);
      sync_n = 1'b0;
      no_sig = VECS[v].ns;
      ex = VECS[v].st;
      for (int i = 0; i < int'(VECS[v].ln); i++) begin
        @(negedge clk);
        chk(VECS[v].ns ? "R7 oe forced off" : "R4 oe during tip", err_oe, VECS[v].ns ? 0 : 1);
        chk(VECS[v].ns ? "R6 err quiet" : "R5 err level", err_out,
            (!VECS[v].ns && ex >= mid) ? 1 : 0);
        ex = (ex + 1) % len;
        chk("R1 count step", hcount, ex);
        if (i == int'(VECS[v].ln) - 1) sync_n = 1'b1;
      end
      @(negedge clk);
      chk("R4 oe after tip", err_oe, 0);
      chk("R6 err after tip", err_out, 0);
      no_sig = 1'b0;
    end

    // R3: mode change exactly at the wrap cycle, then in mid-line
    mode_long = 1'b1;
    wait_href();
    wait_href();
    while (hcount != 10'd701) @(negedge clk);
    mode_long = 1'b0;
    measure_line(n, 0);
    chk("R2 href after long line", hcount, 0);
    measure_line(n, 0);
    chk("R3 switch at wrap gives 638", n, 638);
    measure_line(n, 10);
    chk("R3 mid-line switch ignored", n, 638);
    measure_line(n, 0);
    chk("R3 switch applies next line", n, 702);
    chk("R1 wrap to zero", hcount, 0);

    done = 1'b1;
    summary();
  end

endmodule